// File: doc/BRIEF.md
# UART FIFO Request Signalling for DMA

This block produces the two active-low request pins that a UART presents to a DMA controller or to a polling host. One pin asks for the receive FIFO to be read. The other asks for the transmit FIFO to be written. Both FIFOs are 64 entries deep. The block does not store any data. It keeps an occupancy count for each FIFO, driven by one-cycle push and pop strobes from the FIFO logic around it.

The pins have two modes, chosen by a mode bit. With the mode bit clear, each pin is a plain emptiness indicator. With the mode bit set, each pin becomes a set/reset latch. The latch asserts at one threshold and releases only at the opposite end of the FIFO. This hysteresis lets a DMA engine move a whole block per request.

Each direction has its own 2-bit trigger select. A receive time-out pulse can also raise the receive request. The push and pop strobes are plain qualifiers with no handshake. A push into a full FIFO is dropped without back-pressure, and so is a pop from an empty one. The surrounding logic is expected to gate its strobes with the count outputs.

Top module: `uart_dma_ready`

## Requirements
- R1: While rst_n is low and after its release, both counts are 0, rx_ready_n is 1 and tx_ready_n is 0.
- R2: Each count rises by one on a lone push and falls by one on a lone pop. A lone push at 64 is ignored, and a lone pop at 0 is ignored. A push and a pop in the same cycle leave the count unchanged, even at 0 or 64. A count never exceeds 64.
- R3: With dma_en = 0, rx_ready_n is 1 when the receive count is 0 and 0 otherwise. rx_timeout has no effect in this mode.
- R4: With dma_en = 0, tx_ready_n is 0 when the transmit count is 0 and 1 otherwise.
- R5: A trigger select code maps to a level as follows: 2'b00 is 1, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 56. The same mapping applies to rx_trig_sel and tx_trig_sel.
- R6: With dma_en = 1, rx_ready_n goes to 0 when the receive count is at or above the receive level. It also goes to 0 when rx_timeout is high and the count is nonzero.
- R7: With dma_en = 1, rx_ready_n returns to 1 only when the receive count reaches 0. In every other case it keeps its previous value.
- R8: With dma_en = 1, tx_ready_n goes to 0 when the transmit count is below the transmit level.
- R9: With dma_en = 1, tx_ready_n returns to 1 only when the transmit count reaches 64. In every other case it keeps its previous value.
- R10: On the first clock edge with dma_en = 1 after an edge with dma_en = 0, each latch is evaluated from the current counts as though its previous value were 1. Leaving DMA mode applies the R3 and R4 rules on that same edge.
- R11: On any edge, each request pin takes the value that the rules give for the counts produced by that same edge. The pins never lag the count outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Selects DMA latch mode when 1 |
| rx_trig_sel | input | 2 | Receive trigger level code |
| tx_trig_sel | input | 2 | Transmit trigger level code |
| rx_push | input | 1 | A byte entered the receive FIFO |
| rx_pop | input | 1 | A byte left the receive FIFO |
| tx_push | input | 1 | A byte entered the transmit FIFO |
| tx_pop | input | 1 | A byte left the transmit FIFO |
| rx_timeout | input | 1 | One-cycle receive time-out pulse |
| rx_count | output | 7 | Receive FIFO occupancy |
| tx_count | output | 7 | Transmit FIFO occupancy |
| rx_ready_n | output | 1 | Receive request, active low |
| tx_ready_n | output | 1 | Transmit request, active low |

## Verification
A wrong occupancy count shows on rx_count or tx_count on the edge where it goes wrong. In non-DMA mode it also moves the request pin whenever the wrong count crosses zero. A wrong latch state is harder to see. In DMA mode it persists, and it may stay hidden until the next crossing of the far threshold. For that reason the bench sweeps every trigger code through complete fill and drain runs. It also switches modes while the FIFOs are partly filled, so that a wrong reload shows on the very next cycle.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  typedef logic [1:0] trig_code_t;

  // Level table scaled from the FIFO depth: 1, depth/4, depth/2, depth-depth/8.
  function automatic int unsigned trig_level(input trig_code_t code,
                                             input int unsigned depth);
    int unsigned lvl;
    case (code)
      2'd0:    lvl = 1;
      2'd1:    lvl = depth / 4;
      2'd2:    lvl = depth / 2;
      default: lvl = depth - depth / 8;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/uart_fifo_occ.sv
module uart_fifo_occ #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] count_nxt
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_comb begin
    count_nxt = count_q;
    case ({push, pop})
      2'b10: if (count_q != FULL) count_nxt = count_q + 1'b1;
      2'b01: if (count_q != '0)   count_nxt = count_q - 1'b1;
      default: count_nxt = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_nxt;
  end

endmodule

// File: rtl/uart_rx_req_latch.sv
module uart_rx_req_latch #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          dma_enter,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] level,
  input  logic          timeout,
  output logic          req_n
);

  logic hold_v;
  logic req_d;

  assign hold_v = dma_enter ? 1'b1 : req_n;

  always_comb begin
    if (!dma_en) begin
      req_d = (cnt_nxt == '0);
    end else if (cnt_nxt == '0) begin
      req_d = 1'b1;
    end else if ((cnt_nxt >= level) || timeout) begin
      req_d = 1'b0;
    end else begin
      req_d = hold_v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_n <= 1'b1;
    else        req_n <= req_d;
  end

endmodule

// File: rtl/uart_tx_req_latch.sv
module uart_tx_req_latch #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          dma_enter,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] level,
  output logic          req_n
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic hold_v;
  logic req_d;

  assign hold_v = dma_enter ? 1'b1 : req_n;

  always_comb begin
    if (!dma_en) begin
      req_d = (cnt_nxt != '0);
    end else if (cnt_nxt == FULL) begin
      req_d = 1'b1;
    end else if (cnt_nxt < level) begin
      req_d = 1'b0;
    end else begin
      req_d = hold_v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_n <= 1'b0;
    else        req_n <= req_d;
  end

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic [1:0]    rx_trig_sel,
  input  logic [1:0]    tx_trig_sel,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          tx_push,
  input  logic          tx_pop,
  input  logic          rx_timeout,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_ready_n,
  output logic          tx_ready_n
);

  import uart_dma_pkg::*;

  logic          dma_q;
  logic          dma_enter;
  logic [CW-1:0] rx_lvl;
  logic [CW-1:0] tx_lvl;
  logic [CW-1:0] rx_nxt;
  logic [CW-1:0] tx_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) dma_q <= 1'b0;
    else        dma_q <= dma_en;
  end

  assign dma_enter = dma_en & ~dma_q;
  assign rx_lvl    = CW'(trig_level(rx_trig_sel, DEPTH));
  assign tx_lvl    = CW'(trig_level(tx_trig_sel, DEPTH));

  uart_fifo_occ #(.DEPTH(DEPTH)) rx_occ_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
    .count_q(rx_count), .count_nxt(rx_nxt)
  );

  uart_fifo_occ #(.DEPTH(DEPTH)) tx_occ_i (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
    .count_q(tx_count), .count_nxt(tx_nxt)
  );

  uart_rx_req_latch #(.DEPTH(DEPTH)) rx_req_i (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dma_enter(dma_enter),
    .cnt_nxt(rx_nxt), .level(rx_lvl), .timeout(rx_timeout), .req_n(rx_ready_n)
  );

  uart_tx_req_latch #(.DEPTH(DEPTH)) tx_req_i (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dma_enter(dma_enter),
    .cnt_nxt(tx_nxt), .level(tx_lvl), .req_n(tx_ready_n)
  );

endmodule

// File: rtl/uart_dma_ready_chk.sv
module uart_dma_ready_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_en,
  input logic          rx_timeout,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_ready_n,
  input logic          tx_ready_n
);

  logic dma_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) dma_prev <= 1'b0;
    else        dma_prev <= dma_en;
  end

  AST_RX_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH)); // R2
  AST_TX_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH)); // R2
  AST_RX_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (rx_ready_n == (rx_count == '0))); // R3
  AST_TX_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (tx_ready_n == (tx_count != '0))); // R4
  AST_RX_TIMEOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && rx_timeout) |=> (!rx_ready_n || rx_count == '0)); // R6
  AST_RX_HOLD_TILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_prev && dma_en && !rx_ready_n) |=> (rx_ready_n == (rx_count == '0))); // R7
  AST_TX_HOLD_TILL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_prev && dma_en && !tx_ready_n) |=> (tx_ready_n == (tx_count == CW'(DEPTH)))); // R9

endmodule

bind uart_dma_ready uart_dma_ready_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .rx_timeout(rx_timeout),
  .rx_count(rx_count), .tx_count(tx_count),
  .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n)
);

// File: tb/uart_dma_ready_tb_top.sv
module uart_dma_ready_tb_top;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dma_en;
  logic [1:0] rx_trig_sel, tx_trig_sel;
  logic       rx_push, rx_pop, tx_push, tx_pop, rx_timeout;
  logic [6:0] rx_count, tx_count;
  logic       rx_ready_n, tx_ready_n;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  int m_rx, m_tx;
  bit m_rxn, m_txn, m_dma_prev;

  always #2 clk = ~clk;

  uart_dma_ready dut_i (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
    .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_timeout(rx_timeout), .rx_count(rx_count), .tx_count(tx_count),
    .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n)
  );

  // R5: code to level
  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 16;
      2'd2: return 32;
      default: return 56;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_cnt(input int c, input logic pu, input logic po);
    if (pu && !po && c < DEPTH) return c + 1;
    if (!pu && po && c > 0)     return c - 1;
    return c;
  endfunction

  task automatic compare_all();
    check("R2 rx_count", rx_count, m_rx);
    check("R2 tx_count", tx_count, m_tx);
    check(dma_en ? "R6/R7/R10/R11 rx_ready_n" : "R3/R11 rx_ready_n", rx_ready_n, m_rxn);
    check(dma_en ? "R8/R9/R10/R11 tx_ready_n" : "R4/R11 tx_ready_n", tx_ready_n, m_txn);
  endtask

  task automatic step(input logic rpu, input logic rpo, input logic tpu,
                      input logic tpo, input logic to);
    bit hr, ht;
    rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo; rx_timeout = to;
    @(posedge clk);
    m_rx = next_cnt(m_rx, rpu, rpo);
    m_tx = next_cnt(m_tx, tpu, tpo);
    hr = m_dma_prev ? m_rxn : 1'b1;   // R10 reload
    ht = m_dma_prev ? m_txn : 1'b1;
    if (!dma_en) begin
      m_rxn = (m_rx == 0);
      m_txn = (m_tx != 0);
    end else begin
      if (m_rx == 0)                              m_rxn = 1'b1;
      else if (m_rx >= lvl(rx_trig_sel) || to)    m_rxn = 1'b0;
      else                                        m_rxn = hr;
      if (m_tx == DEPTH)                          m_txn = 1'b1;
      else if (m_tx < lvl(tx_trig_sel))           m_txn = 1'b0;
      else                                        m_txn = ht;
    end
    m_dma_prev = dma_en;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dma_en = 1'b0; rx_trig_sel = 2'd0; tx_trig_sel = 2'd0;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; rx_timeout = 0;
    m_rx = 0; m_tx = 0; m_rxn = 1; m_txn = 0; m_dma_prev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();                 // R1 during reset
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);           // R1 after release

    // Sweep both modes and every trigger code (R5..R9)
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 4; c++) begin
        rx_trig_sel = 2'(c);
        tx_trig_sel = 2'(3 - c);
        dma_en = d[0];
        step(0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0, 0, i == 3); // R6 timeout
        step(1, 1, 0, 0, 0);       // R2 simultaneous at full
        for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 0, 0, 0);      // R7 release at empty
        step(1, 1, 0, 0, 0);       // R2 simultaneous at empty
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1);       // R6 timeout below level
        step(0, 0, 0, 0, 0);       // R7 hold
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);       // R2 pop at empty ignored
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0, 0);      // R9 release at full
        step(0, 0, 1, 1, 0);
        for (int i = 0; i < 50; i++) step(0, 0, 0, 1, 0);             // R8 drop below level
        for (int i = 0; i < 30; i++) step(0, 0, 1, 0, 0);             // R9 hold
        for (int i = 0; i < 45; i++) step(0, 0, 0, 1, 0);
      end
    end

    // R10 mode switching with partly filled FIFOs
    for (int c = 0; c < 4; c++) begin
      rx_trig_sel = 2'(c); tx_trig_sel = 2'(c);
      dma_en = 1'b0;
      for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 0);
      dma_en = 1'b1; step(0, 0, 0, 0, 0);
      step(1, 0, 0, 1, 0);
      dma_en = 1'b0; step(0, 0, 0, 0, 0);
      dma_en = 1'b1; step(0, 0, 0, 0, 1);
      for (int i = 0; i < 25; i++) step(0, 1, 0, 1, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule